// File: doc/BRIEF.md
# Parallel Camera Capture Configurator

This block sits beside a parallel camera capture engine. It turns a geometry
setting (pixels per line, lines per frame, bytes per pixel, data bus width and
the byte pitch between line starts in memory) into the values the capture engine
and its DMA need. Those values are the number of bus cycles per line, the gap
between lines in 8-byte memory words, a DMA burst type with a matching receive
FIFO watermark, and two packing flags. A setting is checked for validity when
it is loaded. An invalid setting raises an error flag and leaves the previously
applied values in force.

Two small controllers are also part of the block. The first runs the FIFO clear
handshake. It switches the automatic clear enable off, raises the selected clear
request lines, waits for the engine to acknowledge, and then puts the enable back
to the value it had before. The second tracks which of the two frame buffers the
next frame goes to. A refresh request sends the following frame back to buffer 0.

Top module: `cam_cfg_top`

## Requirements
- R1: On reset the applied geometry is 320 pixels by 240 lines, 2 bytes per pixel, 8-bit bus and 640-byte pitch. So `line_cycles`=640, `frame_lines`=240, `stride_words`=0, `burst_type`=3, `fifo_level`=2, `pack24`=0, `dual8`=0 and `cfg_err`=0. Also `auto_clr_en`=1, `fifo_clr_bits`=0, `clr_busy`=0, `buf_slot`=0 and `refresh_pend`=0.
- R2: Line bytes are `cfg_width` x bytes per pixel. A load is invalid when the line bytes are not a multiple of 8, when the pitch is not a multiple of 8, or when the pitch is smaller than the line bytes. An invalid load sets `cfg_err` and keeps every derived output at its previous value. A valid load clears `cfg_err`.
- R3: Derived outputs change only in the cycle after a valid `load`. Input changes without `load` have no effect.
- R4: `cfg_bpp_code` value n means n+1 bytes per pixel. `line_cycles` is twice `cfg_width` when the bus is 8 bits (`cfg_bus16`=0) and pixels are 2 bytes. In every other case it equals `cfg_width`.
- R5: `stride_words` = (pitch - line bytes) / 8.
- R6: The burst is chosen from the line bytes. If they are divisible by 128: `burst_type`=3, `fifo_level`=2. Otherwise, if divisible by 64: 2 and 1. In all other cases: 1 and 0.
- R7: `pack24`=1 exactly when pixels are 4 bytes. `dual8`=1 exactly when `cfg_bus16`=1.
- R8: A pulse on `fifo_clr_start` while idle runs the clear sequence. In the following cycle `auto_clr_en`=0 and `clr_busy`=1. One cycle later `fifo_clr_bits` equals the captured `fifo_clr_sel`. The cycle after `fifo_clr_ack` is seen, the bits return to 0. One cycle after that, `auto_clr_en` is back at its value before the sequence and `clr_busy`=0.
- R9: A `fifo_clr_start` that arrives while `clr_busy`=1 is ignored. The bits in flight do not change, and no second sequence follows.
- R10: `buf_slot` gives the buffer of the current frame. It changes only on `frame_start`, and alternates 0,1,0,... starting from 0. `dma_refresh` sets `refresh_pend`. The next `frame_start` then uses buffer 0 and clears `refresh_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Apply the geometry inputs |
| cfg_width | input | W_W | Pixels per line |
| cfg_height | input | H_W | Lines per frame |
| cfg_bpp_code | input | 2 | Bytes per pixel minus one |
| cfg_bus16 | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| cfg_pitch | input | P_W | Bytes between line starts in memory |
| cfg_clr_en | input | 1 | Auto-clear enable value applied on a valid load |
| fifo_clr_start | input | 1 | Start a FIFO clear sequence |
| fifo_clr_sel | input | 2 | FIFOs to clear (bit 0 receive, bit 1 statistics) |
| fifo_clr_ack | input | 1 | Engine has finished the clear |
| frame_start | input | 1 | A new frame begins |
| dma_refresh | input | 1 | Restart buffer alternation at buffer 0 |
| cfg_err | output | 1 | Last load was invalid |
| line_cycles | output | W_W+1 | Bus cycles per line |
| frame_lines | output | H_W | Applied lines per frame |
| stride_words | output | P_W-3 | Line gap in 8-byte words |
| burst_type | output | 2 | DMA burst type |
| fifo_level | output | 2 | Receive FIFO watermark |
| pack24 | output | 1 | 24-bit packing mode |
| dual8 | output | 1 | Two 8-bit sensor lanes |
| auto_clr_en | output | 1 | Automatic FIFO clear enable |
| fifo_clr_bits | output | 2 | Clear request lines to the engine |
| clr_busy | output | 1 | Clear sequence in progress |
| buf_slot | output | 1 | Buffer of the current frame |
| refresh_pend | output | 1 | Refresh waiting for the next frame |

## Verification
The bench uses the default parameters: 12-bit width, 12-bit height and 16-bit pitch. These are wide enough for pitches up to 1024 bytes and line byte counts well past 128. That lets the vector table reach all three burst classes, non-zero strides, and both the doubled and the plain cycle count. Rejected settings are placed between valid ones so that held values can be told apart from reset values. The clear sequence is run once with a prior enable of 1 and once with 0.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;
  // alignment thresholds (log2 of bytes) for the burst classes
  localparam int BIG_ALIGN_LOG2 = 7;
  localparam int MID_ALIGN_LOG2 = 6;
  localparam int BEAT_LOG2      = 3;

  localparam logic [1:0] BURST_BIG   = 2'd3;
  localparam logic [1:0] BURST_MID   = 2'd2;
  localparam logic [1:0] BURST_SMALL = 2'd1;

  typedef enum logic [1:0] {
    CS_IDLE    = 2'd0,
    CS_DROP    = 2'd1,
    CS_REQ     = 2'd2,
    CS_RESTORE = 2'd3
  } clr_state_t;
endpackage

// File: rtl/cam_cfg_calc.sv
module cam_cfg_calc
  import cam_cfg_pkg::*;
#(
  parameter int W_W = 12,
  parameter int P_W = 16,
  localparam int LB_W  = W_W + 3,
  localparam int CMP_W = (LB_W > P_W) ? LB_W : P_W,
  localparam int ST_W  = P_W - BEAT_LOG2,
  localparam int LC_W  = W_W + 1
) (
  input  logic [W_W-1:0]  width,
  input  logic [1:0]      bpp_code,
  input  logic            bus16,
  input  logic [P_W-1:0]  pitch,
  output logic            valid,
  output logic [LC_W-1:0] lc,
  output logic [ST_W-1:0] stride,
  output logic [1:0]      burst,
  output logic [1:0]      level,
  output logic            pack24,
  output logic            dual8
);
  logic [LB_W-1:0]  line_bytes;
  logic [CMP_W-1:0] lb_x;
  logic [CMP_W-1:0] pitch_x;
  logic [CMP_W-1:0] gap;

  always_comb begin
    line_bytes = LB_W'(width) * LB_W'({1'b0, bpp_code} + 3'd1);
    lb_x       = CMP_W'(line_bytes);
    pitch_x    = CMP_W'(pitch);
    gap        = pitch_x - lb_x;

    valid = (line_bytes[BEAT_LOG2-1:0] == '0) &&
            (pitch[BEAT_LOG2-1:0] == '0) &&
            (pitch_x >= lb_x);

    stride = ST_W'(gap >> BEAT_LOG2);

    if (!bus16 && (bpp_code == 2'd1)) lc = {width, 1'b0};
    else                              lc = {1'b0, width};

    if (line_bytes[BIG_ALIGN_LOG2-1:0] == '0) begin
      burst = BURST_BIG;   level = 2'd2;
    end else if (line_bytes[MID_ALIGN_LOG2-1:0] == '0) begin
      burst = BURST_MID;   level = 2'd1;
    end else begin
      burst = BURST_SMALL; level = 2'd0;
    end

    pack24 = (bpp_code == 2'd3);
    dual8  = bus16;
  end
endmodule

// File: rtl/cam_fifo_clr_seq.sv
module cam_fifo_clr_seq
  import cam_cfg_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_load,
  input  logic             en_val,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  input  logic             ack,
  output logic             auto_en,
  output logic [SEL_W-1:0] clr_bits,
  output logic             busy
);
  clr_state_t       state;
  logic             saved_en;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CS_IDLE;
      auto_en  <= 1'b1;
      saved_en <= 1'b1;
      sel_q    <= '0;
      clr_bits <= '0;
    end else begin
      unique case (state)
        CS_IDLE: begin
          if (start) begin
            saved_en <= auto_en;
            auto_en  <= 1'b0;
            sel_q    <= sel;
            state    <= CS_DROP;
          end else if (en_load) begin
            auto_en <= en_val;
          end
        end
        CS_DROP: begin
          clr_bits <= sel_q;
          state    <= CS_REQ;
        end
        CS_REQ: begin
          if (ack) begin
            clr_bits <= '0;
            state    <= CS_RESTORE;
          end
        end
        CS_RESTORE: begin
          auto_en <= saved_en;
          state   <= CS_IDLE;
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  assign busy = (state != CS_IDLE);
endmodule

// File: rtl/cam_buf_slot.sv
module cam_buf_slot (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic refresh_req,
  output logic slot,
  output logic pend
);
  logic next_slot;
  logic eff_slot;

  assign eff_slot = pend ? 1'b0 : next_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= 1'b0;
      next_slot <= 1'b0;
      pend      <= 1'b0;
    end else begin
      if (frame_start) begin
        slot      <= eff_slot;
        next_slot <= ~eff_slot;
      end
      pend <= refresh_req | (pend & ~frame_start);
    end
  end
endmodule

// File: rtl/cam_cfg_top.sv
module cam_cfg_top
  import cam_cfg_pkg::*;
#(
  parameter int W_W        = 12,
  parameter int H_W        = 12,
  parameter int P_W        = 16,
  parameter int DEF_WIDTH  = 320,
  parameter int DEF_HEIGHT = 240,
  parameter int DEF_BPP    = 2,
  parameter int DEF_PITCH  = 640,
  localparam int LC_W = W_W + 1,
  localparam int ST_W = P_W - BEAT_LOG2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [W_W-1:0]  cfg_width,
  input  logic [H_W-1:0]  cfg_height,
  input  logic [1:0]      cfg_bpp_code,
  input  logic            cfg_bus16,
  input  logic [P_W-1:0]  cfg_pitch,
  input  logic            cfg_clr_en,
  input  logic            fifo_clr_start,
  input  logic [1:0]      fifo_clr_sel,
  input  logic            fifo_clr_ack,
  input  logic            frame_start,
  input  logic            dma_refresh,
  output logic            cfg_err,
  output logic [LC_W-1:0] line_cycles,
  output logic [H_W-1:0]  frame_lines,
  output logic [ST_W-1:0] stride_words,
  output logic [1:0]      burst_type,
  output logic [1:0]      fifo_level,
  output logic            pack24,
  output logic            dual8,
  output logic            auto_clr_en,
  output logic [1:0]      fifo_clr_bits,
  output logic            clr_busy,
  output logic            buf_slot,
  output logic            refresh_pend
);
  // during reset the calculator sees the default geometry
  logic [W_W-1:0]  src_width;
  logic [H_W-1:0]  src_height;
  logic [1:0]      src_bpp;
  logic            src_bus16;
  logic [P_W-1:0]  src_pitch;

  assign src_width  = rst ? W_W'(DEF_WIDTH)     : cfg_width;
  assign src_height = rst ? H_W'(DEF_HEIGHT)    : cfg_height;
  assign src_bpp    = rst ? 2'(DEF_BPP - 1)     : cfg_bpp_code;
  assign src_bus16  = rst ? 1'b0                : cfg_bus16;
  assign src_pitch  = rst ? P_W'(DEF_PITCH)     : cfg_pitch;

  logic            c_valid;
  logic [LC_W-1:0] c_lc;
  logic [ST_W-1:0] c_stride;
  logic [1:0]      c_burst;
  logic [1:0]      c_level;
  logic            c_pack24;
  logic            c_dual8;

  cam_cfg_calc #(.W_W(W_W), .P_W(P_W)) u_calc (
    .width    (src_width),
    .bpp_code (src_bpp),
    .bus16    (src_bus16),
    .pitch    (src_pitch),
    .valid    (c_valid),
    .lc       (c_lc),
    .stride   (c_stride),
    .burst    (c_burst),
    .level    (c_level),
    .pack24   (c_pack24),
    .dual8    (c_dual8)
  );

  logic apply;
  assign apply = rst | (load & c_valid);

  always_ff @(posedge clk) begin
    if (apply) begin
      line_cycles  <= c_lc;
      frame_lines  <= src_height;
      stride_words <= c_stride;
      burst_type   <= c_burst;
      fifo_level   <= c_level;
      pack24       <= c_pack24;
      dual8        <= c_dual8;
    end
    if (rst)       cfg_err <= 1'b0;
    else if (load) cfg_err <= ~c_valid;
  end

  cam_fifo_clr_seq #(.SEL_W(2)) u_clr (
    .clk      (clk),
    .rst      (rst),
    .en_load  (load & c_valid),
    .en_val   (cfg_clr_en),
    .start    (fifo_clr_start),
    .sel      (fifo_clr_sel),
    .ack      (fifo_clr_ack),
    .auto_en  (auto_clr_en),
    .clr_bits (fifo_clr_bits),
    .busy     (clr_busy)
  );

  cam_buf_slot u_slot (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .refresh_req (dma_refresh),
    .slot        (buf_slot),
    .pend        (refresh_pend)
  );
endmodule

// File: rtl/cam_cfg_chk.sv
module cam_cfg_chk #(
  parameter int LC_W = 13,
  parameter int ST_W = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            load,
  input logic            frame_start,
  input logic            dma_refresh,
  input logic            cfg_err,
  input logic [LC_W-1:0] line_cycles,
  input logic [ST_W-1:0] stride_words,
  input logic [1:0]      burst_type,
  input logic [1:0]      fifo_level,
  input logic            auto_clr_en,
  input logic [1:0]      fifo_clr_bits,
  input logic            clr_busy,
  input logic            buf_slot,
  input logic            refresh_pend
);
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(line_cycles) && $stable(stride_words) && $stable(burst_type))); // R3
  AST_ERR_STICKS: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !load) |=> cfg_err); // R2
  AST_BURST_LEVEL_PAIR: assert property (@(posedge clk) disable iff (rst)
    (burst_type != 2'd0) && (fifo_level == burst_type - 2'd1)); // R6
  AST_EN_OFF_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    clr_busy |-> !auto_clr_en); // R8
  AST_BITS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (fifo_clr_bits != 2'b00) |-> clr_busy); // R8
  AST_BITS_STEADY: assert property (@(posedge clk) disable iff (rst)
    (fifo_clr_bits != 2'b00) |=> (fifo_clr_bits == $past(fifo_clr_bits) || fifo_clr_bits == 2'b00)); // R9
  AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(buf_slot)); // R10
  AST_REFRESH_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (refresh_pend && frame_start && !dma_refresh) |=> (!buf_slot && !refresh_pend)); // R10
endmodule

bind cam_cfg_top cam_cfg_chk #(.LC_W(LC_W), .ST_W(ST_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .load         (load),
  .frame_start  (frame_start),
  .dma_refresh  (dma_refresh),
  .cfg_err      (cfg_err),
  .line_cycles  (line_cycles),
  .stride_words (stride_words),
  .burst_type   (burst_type),
  .fifo_level   (fifo_level),
  .auto_clr_en  (auto_clr_en),
  .fifo_clr_bits(fifo_clr_bits),
  .clr_busy     (clr_busy),
  .buf_slot     (buf_slot),
  .refresh_pend (refresh_pend)
);

// File: tb/cam_cfg_top_bench.sv
module cam_cfg_top_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [11:0] w;
    logic [1:0]  bc;
    logic        b16;
    logic [15:0] p;
    logic        e;
    logic [12:0] lc;
    logic [12:0] st;
    logic [1:0]  bt;
    logic [1:0]  lv;
    logic        pk;
    logic        d8;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{12'd320, 2'd1, 1'b0, 16'd640,  1'b0, 13'd640, 13'd0,  2'd3, 2'd2, 1'b0, 1'b0},
    '{12'd320, 2'd1, 1'b1, 16'd1024, 1'b0, 13'd320, 13'd48, 2'd3, 2'd2, 1'b0, 1'b1},
    '{12'd8,   2'd0, 1'b0, 16'd64,   1'b0, 13'd8,   13'd7,  2'd1, 2'd0, 1'b0, 1'b0},
    '{12'd16,  2'd3, 1'b0, 16'd64,   1'b0, 13'd16,  13'd0,  2'd2, 2'd1, 1'b1, 1'b0},
    '{12'd96,  2'd1, 1'b0, 16'd256,  1'b0, 13'd192, 13'd8,  2'd2, 2'd1, 1'b0, 1'b0},
    '{12'd100, 2'd1, 1'b0, 16'd200,  1'b0, 13'd200, 13'd0,  2'd1, 2'd0, 1'b0, 1'b0},
    '{12'd24,  2'd2, 1'b0, 16'd80,   1'b0, 13'd24,  13'd1,  2'd1, 2'd0, 1'b0, 1'b0},
    '{12'd3,   2'd0, 1'b0, 16'd64,   1'b1, 13'd24,  13'd1,  2'd1, 2'd0, 1'b0, 1'b0},
    '{12'd8,   2'd0, 1'b0, 16'd68,   1'b1, 13'd24,  13'd1,  2'd1, 2'd0, 1'b0, 1'b0},
    '{12'd32,  2'd1, 1'b0, 16'd32,   1'b1, 13'd24,  13'd1,  2'd1, 2'd0, 1'b0, 1'b0},
    '{12'd64,  2'd1, 1'b1, 16'd128,  1'b0, 13'd64,  13'd0,  2'd3, 2'd2, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [11:0] cfg_width = '0;
  logic [11:0] cfg_height = '0;
  logic [1:0]  cfg_bpp_code = '0;
  logic        cfg_bus16 = 1'b0;
  logic [15:0] cfg_pitch = '0;
  logic        cfg_clr_en = 1'b1;
  logic        fifo_clr_start = 1'b0;
  logic [1:0]  fifo_clr_sel = '0;
  logic        fifo_clr_ack = 1'b0;
  logic        frame_start = 1'b0;
  logic        dma_refresh = 1'b0;

  logic        cfg_err;
  logic [12:0] line_cycles;
  logic [11:0] frame_lines;
  logic [12:0] stride_words;
  logic [1:0]  burst_type;
  logic [1:0]  fifo_level;
  logic        pack24;
  logic        dual8;
  logic        auto_clr_en;
  logic [1:0]  fifo_clr_bits;
  logic        clr_busy;
  logic        buf_slot;
  logic        refresh_pend;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_cfg_top u_cam_cfg_top (
    .clk(clk), .rst(rst), .load(load), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_bpp_code(cfg_bpp_code), .cfg_bus16(cfg_bus16), .cfg_pitch(cfg_pitch),
    .cfg_clr_en(cfg_clr_en), .fifo_clr_start(fifo_clr_start), .fifo_clr_sel(fifo_clr_sel),
    .fifo_clr_ack(fifo_clr_ack), .frame_start(frame_start), .dma_refresh(dma_refresh),
    .cfg_err(cfg_err), .line_cycles(line_cycles), .frame_lines(frame_lines),
    .stride_words(stride_words), .burst_type(burst_type), .fifo_level(fifo_level),
    .pack24(pack24), .dual8(dual8), .auto_clr_en(auto_clr_en),
    .fifo_clr_bits(fifo_clr_bits), .clr_busy(clr_busy), .buf_slot(buf_slot),
    .refresh_pend(refresh_pend)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply_vec(input vec_t v, input logic clr_en);
    cfg_width = v.w; cfg_bpp_code = v.bc; cfg_bus16 = v.b16; cfg_pitch = v.p;
    cfg_height = 12'd100; cfg_clr_en = clr_en; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    chk("R2", $sformatf("v%0d err", idx), cfg_err, v.e);
    chk("R4", $sformatf("v%0d line_cycles", idx), line_cycles, v.lc);
    chk("R5", $sformatf("v%0d stride", idx), stride_words, v.st);
    chk("R6", $sformatf("v%0d burst", idx), burst_type, v.bt);
    chk("R6", $sformatf("v%0d level", idx), fifo_level, v.lv);
    chk("R7", $sformatf("v%0d pack24", idx), pack24, v.pk);
    chk("R7", $sformatf("v%0d dual8", idx), dual8, v.d8);
  endtask

  task automatic clear_run(input logic [1:0] sel, input logic exp_en);
    fifo_clr_sel = sel; fifo_clr_start = 1'b1;
    @(negedge clk);
    fifo_clr_start = 1'b0;
    chk("R8", "busy after start", clr_busy, 1);
    chk("R8", "enable dropped", auto_clr_en, 0);
    chk("R8", "bits not yet", fifo_clr_bits, 0);
    @(negedge clk);
    chk("R8", "bits raised", fifo_clr_bits, sel);
    // R9: second request while busy
    fifo_clr_sel = ~sel; fifo_clr_start = 1'b1;
    @(negedge clk);
    fifo_clr_start = 1'b0;
    chk("R9", "bits unchanged by request while busy", fifo_clr_bits, sel);
    @(negedge clk);
    chk("R8", "bits held without ack", fifo_clr_bits, sel);
    fifo_clr_ack = 1'b1;
    @(negedge clk);
    fifo_clr_ack = 1'b0;
    chk("R8", "bits dropped after ack", fifo_clr_bits, 0);
    chk("R8", "enable still off", auto_clr_en, 0);
    @(negedge clk);
    chk("R8", "enable restored", auto_clr_en, exp_en);
    chk("R8", "idle after restore", clr_busy, 0);
    @(negedge clk);
    chk("R9", "no second sequence", clr_busy, 0);
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "err", cfg_err, 0);
    chk("R1", "line_cycles", line_cycles, 640);
    chk("R1", "frame_lines", frame_lines, 240);
    chk("R1", "stride", stride_words, 0);
    chk("R1", "burst", burst_type, 3);
    chk("R1", "level", fifo_level, 2);
    chk("R1", "pack24", pack24, 0);
    chk("R1", "dual8", dual8, 0);
    chk("R1", "auto_clr_en", auto_clr_en, 1);
    chk("R1", "clr_bits", fifo_clr_bits, 0);
    chk("R1", "busy", clr_busy, 0);
    chk("R1", "slot", buf_slot, 0);
    chk("R1", "pend", refresh_pend, 0);

    // R3: inputs change without load
    cfg_width = 12'd8; cfg_bpp_code = 2'd0; cfg_pitch = 16'd64; cfg_bus16 = 1'b1;
    cfg_height = 12'd7;
    repeat (2) @(negedge clk);
    chk("R3", "line_cycles without load", line_cycles, 640);
    chk("R3", "frame_lines without load", frame_lines, 240);
    chk("R3", "dual8 without load", dual8, 0);

    for (int i = 0; i < NV; i++) begin
      apply_vec(VEC[i], 1'b1);
      check_vec(VEC[i], i);
    end
    chk("R3", "frame_lines after valid load", frame_lines, 100);

    // R8 and R9 with prior enable 1
    clear_run(2'b01, 1'b1);
    // prior enable 0
    apply_vec(VEC[0], 1'b0);
    chk("R2", "enable taken on valid load", auto_clr_en, 0);
    clear_run(2'b10, 1'b0);

    // R10 buffer alternation and refresh
    frame();
    chk("R10", "first frame slot", buf_slot, 0);
    frame();
    chk("R10", "second frame slot", buf_slot, 1);
    frame();
    chk("R10", "third frame slot", buf_slot, 0);
    dma_refresh = 1'b1;
    @(negedge clk);
    dma_refresh = 1'b0;
    chk("R10", "refresh pending", refresh_pend, 1);
    chk("R10", "slot steady without frame", buf_slot, 0);
    frame();
    chk("R10", "refresh forces slot 0", buf_slot, 0);
    chk("R10", "refresh cleared", refresh_pend, 0);
    frame();
    chk("R10", "alternation resumes", buf_slot, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule